// File: doc/BRIEF.md
# Guest Trap Decision Unit

This block sits beside the guest-mode decode stage. Each cycle it looks at the event that just finished decoding: an instruction class, an exception vector, or an I/O port access. It also looks at the external interrupt request and at the guest's own interrupt-enable flag. From these it decides whether control must leave the guest and return to the monitor. When a trap is taken, the block raises a one-clock pulse together with an exit-reason code and an exit-qualification word. It also reports whether external interrupts are effectively masked.

The monitor sets the trap policy through a small write port. Address 0 holds a control word. Address 1 holds a 32-bit exception bitmap, one bit per vector. Addresses from 2 upward hold an I/O bitmap with one bit per port: port p uses word 2 + p/32, bit p%32. All policy lives in local registers. A write takes effect for events in the cycle after the write.

Control word fields:
- Bits 6:0 enable the gated instruction classes 3 to 9. Bit (class-3) enables class `class`.
- Bit 7 enables external-interrupt exiting.
- Bit 8 enables interrupt-window exiting.
- Bits 9, 10 and 11 make writes to control registers 0, 3 and 4 trap.

Top module: `guest_trap_unit`

## Requirements
- R1: After reset, trapPulse, exitReason, exitQual and all policy registers are zero. intMasked equals the inverse of guestIf.
- R2: The following instructions trap even when every control bit is clear, with the reason and qualification shown:

  | Instruction | Reason | Qualification |
  |---|---|---|
  | Class 0 (CPU identification) | 3 | class code |
  | Class 1 (model-specific read) | 3 | class code |
  | Class 2 (model-specific write) | 3 | class code |
  | Class 10 (control-register move) reading register 3 | 4 (control-register access) | CR-move format of R8 |

- R3: Classes 3 to 9 (halt, TLB invalidate, task-priority move, debug-register move, monitor-wait, performance-counter read, timestamp read) trap with reason 3 only when control bit (class-3) is set. Classes 12 to 15 never trap.
- R4: An exception event with vector v traps with reason 2 and qualification v only when exception-bitmap bit v is 1.
- R5: Class 11 (I/O access) on port p traps with reason 5 and qualification p only when I/O bitmap bit p is set.
- R6: With control bit 7 set, an external interrupt request traps with reason 1 and qualification 0, whatever guestIf holds, and intMasked is 0. With bit 7 clear, requests never trap and intMasked is the inverse of guestIf.
- R7: With control bit 8 set, the first cycle in which guestIf is 1 gives one trap with reason 6 and qualification 0. After that, no further window trap occurs until the control word is written again.
- R8: A class-10 write traps (reason 4) when the target register is 0, 3 or 4 and its enable bit (9, 10 or 11) is set. Writes to other registers and reads of registers other than 3 never trap. The qualification holds the register number in bits 3:0, the write flag in bit 4 and the general-purpose register index in bits 11:8.
- R9: When several causes occur in the same cycle, the reason is chosen in this order: external interrupt first, then exception, then instruction (reasons 3, 4 or 5), then interrupt window.
- R10: No trap is raised in a cycle where guestMode is low.
- R11: trapPulse goes high for exactly the one clock after the cycle in which the cause was presented. exitReason and exitQual keep their values until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Policy register write strobe |
| cfgAddr | input | CFG_AW | Policy register address |
| cfgData | input | 32 | Policy write data |
| guestMode | input | 1 | Guest is running |
| evValid | input | 1 | A decoded event is present |
| evIsExc | input | 1 | Event is an exception (1) or an instruction (0) |
| instrClass | input | 4 | Instruction class code |
| excVector | input | 5 | Exception vector |
| ioPort | input | PORT_W | I/O port number |
| crNum | input | 4 | Control register number of a CR move |
| crWrite | input | 1 | CR move direction, 1 means write |
| gprIdx | input | 4 | General-purpose register used by a CR move |
| extIrq | input | 1 | External interrupt request |
| guestIf | input | 1 | Guest interrupt-enable flag |
| trapPulse | output | 1 | One-clock trap indication |
| exitReason | output | 3 | Reason code of the last trap |
| exitQual | output | QUAL_W | Qualification of the last trap |
| intMasked | output | 1 | External interrupts effectively masked |

## Verification
Exceptions and instructions cannot arrive together, because one event is only one kind. The collisions that can happen are an external interrupt or a pending window trap landing in the same cycle as a decoded event. The bench provokes this by raising extIrq alongside a trapping exception, and by arming the window while an exception or an always-trapping instruction is presented. It checks that the winner's reason and qualification appear. It also checks that the window trap, having lost, fires on the next free cycle and then goes quiet until it is rearmed.

// File: rtl/gtu_pkg.sv
package gtu_pkg;
  typedef enum logic [2:0] {
    RSN_NONE   = 3'd0,
    RSN_EXTINT = 3'd1,
    RSN_EXCEPT = 3'd2,
    RSN_INSTR  = 3'd3,
    RSN_CRACC  = 3'd4,
    RSN_IOPORT = 3'd5,
    RSN_WINDOW = 3'd6
  } exit_reason_e;

  localparam logic [3:0] CLS_CPUID    = 4'd0;
  localparam logic [3:0] CLS_MSRWR    = 4'd2;
  localparam logic [3:0] CLS_GATED_LO = 4'd3;
  localparam logic [3:0] CLS_GATED_HI = 4'd9;
  localparam logic [3:0] CLS_MOVCR    = 4'd10;
  localparam logic [3:0] CLS_IOACC    = 4'd11;

  localparam int BIT_EXT_EXIT = 7;
  localparam int BIT_WIN_EXIT = 8;
  localparam int BIT_CR0_WR   = 9;
  localparam int BIT_CR3_WR   = 10;
  localparam int BIT_CR4_WR   = 11;
  localparam int CTRL_W       = 12;

  // lookups the datapath hands to the control
  typedef struct packed {
    logic excHit;
    logic ioHit;
    logic gatedHit;
    logic crHit;
    logic extExit;
    logic windowArm;
  } trap_hits_t;

  // strobes the control hands back to the datapath
  typedef struct packed {
    logic         fire;
    exit_reason_e reason;
    logic         windowTaken;
  } trap_strobe_t;
endpackage

// File: rtl/gtu_datapath.sv
module gtu_datapath
  import gtu_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int QUAL_W = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic [3:0]        instrClass,
  input  logic [4:0]        excVector,
  input  logic [PORT_W-1:0] ioPort,
  input  logic [3:0]        crNum,
  input  logic              crWrite,
  input  logic [3:0]        gprIdx,
  input  trap_strobe_t      strobe,
  output trap_hits_t        hits,
  output logic              trapPulse,
  output logic [2:0]        exitReason,
  output logic [QUAL_W-1:0] exitQual
);
  localparam int IO_WORDS = 2 ** (PORT_W - 5);
  localparam int IO_BITS  = IO_WORDS * 32;
  localparam int IO_BASE  = 2;

  logic [CTRL_W-1:0]  ctrlWord;
  logic [31:0]        excMap;
  logic [IO_BITS-1:0] ioFlat;
  logic               windowDone;
  logic               ctrlWr;
  logic [QUAL_W-1:0]  qualNext;

  assign ctrlWr = cfgWe && (cfgAddr == CFG_AW'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord   <= '0;
      excMap     <= '0;
      windowDone <= 1'b0;
    end else begin
      if (ctrlWr) ctrlWord <= cfgData[CTRL_W-1:0];
      if (cfgWe && cfgAddr == CFG_AW'(1)) excMap <= cfgData;
      if (ctrlWr) windowDone <= 1'b0;
      else if (strobe.windowTaken) windowDone <= 1'b1;
    end
  end

  for (genvar g = 0; g < IO_WORDS; g++) begin : g_ioWord
    logic [31:0] word;
    always_ff @(posedge clk) begin
      if (!rstN) word <= '0;
      else if (cfgWe && cfgAddr == CFG_AW'(g + IO_BASE)) word <= cfgData;
    end
    assign ioFlat[g*32 +: 32] = word;
  end

  always_comb begin
    hits.excHit    = excMap[excVector];
    hits.ioHit     = ioFlat[ioPort];
    hits.gatedHit  = (instrClass >= CLS_GATED_LO) && (instrClass <= CLS_GATED_HI)
                     && ctrlWord[4'(instrClass - CLS_GATED_LO)];
    if (crWrite)
      hits.crHit = (crNum == 4'd0 && ctrlWord[BIT_CR0_WR])
                || (crNum == 4'd3 && ctrlWord[BIT_CR3_WR])
                || (crNum == 4'd4 && ctrlWord[BIT_CR4_WR]);
    else
      hits.crHit = (crNum == 4'd3);
    hits.extExit   = ctrlWord[BIT_EXT_EXIT];
    hits.windowArm = ctrlWord[BIT_WIN_EXIT] && !windowDone;
  end

  always_comb begin
    unique case (strobe.reason)
      RSN_EXCEPT: qualNext = QUAL_W'(excVector);
      RSN_INSTR:  qualNext = QUAL_W'(instrClass);
      RSN_CRACC:  qualNext = QUAL_W'({gprIdx, 3'b000, crWrite, crNum});
      RSN_IOPORT: qualNext = QUAL_W'(ioPort);
      default:    qualNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPulse  <= 1'b0;
      exitReason <= RSN_NONE;
      exitQual   <= '0;
    end else begin
      trapPulse <= strobe.fire;
      if (strobe.fire) begin
        exitReason <= strobe.reason;
        exitQual   <= qualNext;
      end
    end
  end
endmodule

// File: rtl/gtu_ctrl.sv
module gtu_ctrl
  import gtu_pkg::*;
(
  input  logic         guestMode,
  input  logic         evValid,
  input  logic         evIsExc,
  input  logic [3:0]   instrClass,
  input  logic         extIrq,
  input  logic         guestIf,
  input  trap_hits_t   hits,
  output trap_strobe_t strobe
);
  logic         extCause, excCause, instCause, winCause, isInstr;
  exit_reason_e instReason;

  assign isInstr = evValid && !evIsExc;

  always_comb begin
    instReason = RSN_INSTR;
    instCause  = 1'b0;
    if (instrClass == CLS_MOVCR) begin
      instReason = RSN_CRACC;
      instCause  = hits.crHit;
    end else if (instrClass == CLS_IOACC) begin
      instReason = RSN_IOPORT;
      instCause  = hits.ioHit;
    end else begin
      instCause  = (instrClass <= CLS_MSRWR) || hits.gatedHit;
    end
  end

  assign extCause = extIrq && hits.extExit;
  assign excCause = evValid && evIsExc && hits.excHit;
  assign winCause = hits.windowArm && guestIf;

  always_comb begin
    strobe = '{fire: 1'b0, reason: RSN_NONE, windowTaken: 1'b0};
    if (guestMode) begin
      if (extCause)                   strobe.reason = RSN_EXTINT;
      else if (excCause)              strobe.reason = RSN_EXCEPT;
      else if (isInstr && instCause)  strobe.reason = instReason;
      else if (winCause)              strobe.reason = RSN_WINDOW;
      strobe.fire        = (strobe.reason != RSN_NONE);
      strobe.windowTaken = (strobe.reason == RSN_WINDOW);
    end
  end
endmodule

// File: rtl/guest_trap_unit.sv
module guest_trap_unit
  import gtu_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int QUAL_W = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              guestMode,
  input  logic              evValid,
  input  logic              evIsExc,
  input  logic [3:0]        instrClass,
  input  logic [4:0]        excVector,
  input  logic [PORT_W-1:0] ioPort,
  input  logic [3:0]        crNum,
  input  logic              crWrite,
  input  logic [3:0]        gprIdx,
  input  logic              extIrq,
  input  logic              guestIf,
  output logic              trapPulse,
  output logic [2:0]        exitReason,
  output logic [QUAL_W-1:0] exitQual,
  output logic              intMasked
);
  trap_hits_t   hits;
  trap_strobe_t strobe;

  gtu_ctrl u_ctrl (
    .guestMode(guestMode), .evValid(evValid), .evIsExc(evIsExc),
    .instrClass(instrClass), .extIrq(extIrq), .guestIf(guestIf),
    .hits(hits), .strobe(strobe)
  );

  gtu_datapath #(.PORT_W(PORT_W), .QUAL_W(QUAL_W), .CFG_AW(CFG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .instrClass(instrClass), .excVector(excVector), .ioPort(ioPort),
    .crNum(crNum), .crWrite(crWrite), .gprIdx(gprIdx), .strobe(strobe),
    .hits(hits), .trapPulse(trapPulse), .exitReason(exitReason), .exitQual(exitQual)
  );

  // guest masking counts only while external interrupts stay with the guest
  assign intMasked = !hits.extExit && !guestIf;
endmodule

// File: rtl/gtu_checker.sv
module gtu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       guestMode,
  input logic       evValid,
  input logic       evIsExc,
  input logic [3:0] instrClass,
  input logic       extIrq,
  input logic       guestIf,
  input logic       trapPulse,
  input logic [2:0] exitReason,
  input logic       intMasked
);
  // R10: outside guest mode nothing traps
  p_guest_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !guestMode |=> !trapPulse);

  // R11: reason is held between traps
  p_reason_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !trapPulse |-> $stable(exitReason));

  // R11: a trap always carries a real reason
  p_reason_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> exitReason != 3'd0);

  // R2: always-trapping class traps next cycle
  p_uncond_r2: assert property (@(posedge clk) disable iff (!rstN)
    guestMode && evValid && !evIsExc && instrClass == 4'd0 && !extIrq
      |=> trapPulse && exitReason == 3'd3);

  // R6 / R9: unmasked-by-monitor interrupt wins with reason 1
  p_ext_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    guestMode && extIrq && !intMasked && !guestIf
      |=> trapPulse && exitReason == 3'd1);

  // R9: an exception cannot be outranked by instruction or window
  p_exc_prio_r9: assert property (@(posedge clk) disable iff (!rstN)
    guestMode && evValid && evIsExc && !extIrq
      |=> !trapPulse || exitReason == 3'd2 || exitReason == 3'd6);
endmodule

bind guest_trap_unit gtu_checker u_chk (
  .clk(clk), .rstN(rstN), .guestMode(guestMode), .evValid(evValid),
  .evIsExc(evIsExc), .instrClass(instrClass), .extIrq(extIrq),
  .guestIf(guestIf), .trapPulse(trapPulse), .exitReason(exitReason),
  .intMasked(intMasked)
);

// File: tb/guest_trap_unit_tb.sv
module guest_trap_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 0;
  logic [3:0]  cfgAddr = 0;
  logic [31:0] cfgData = 0;
  logic        guestMode = 0, evValid = 0, evIsExc = 0;
  logic [3:0]  instrClass = 0;
  logic [4:0]  excVector = 0;
  logic [7:0]  ioPort = 0;
  logic [3:0]  crNum = 0, gprIdx = 0;
  logic        crWrite = 0, extIrq = 0, guestIf = 0;
  logic        trapPulse, intMasked;
  logic [2:0]  exitReason;
  logic [31:0] exitQual;

  int checks = 0;
  int fails = 0;

  // behavioural model state
  bit [11:0] mCtrl = 0;
  bit [31:0] mExc = 0;
  bit [31:0] mIo [8];
  bit        mWinDone = 0;
  bit        expTrap = 0;
  int        expReason = 0;
  int        expQual = 0;

  guest_trap_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .guestMode(guestMode), .evValid(evValid), .evIsExc(evIsExc),
    .instrClass(instrClass), .excVector(excVector), .ioPort(ioPort),
    .crNum(crNum), .crWrite(crWrite), .gprIdx(gprIdx), .extIrq(extIrq),
    .guestIf(guestIf), .trapPulse(trapPulse), .exitReason(exitReason),
    .exitQual(exitQual), .intMasked(intMasked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int instrReason(int cls);
    if (cls <= 2) return 3;
    if (cls <= 9) return mCtrl[cls-3] ? 3 : 0;
    if (cls == 10) begin
      if (!crWrite) return (crNum == 3) ? 4 : 0;
      if (crNum == 0) return mCtrl[9] ? 4 : 0;
      if (crNum == 3) return mCtrl[10] ? 4 : 0;
      if (crNum == 4) return mCtrl[11] ? 4 : 0;
      return 0;
    end
    if (cls == 11) return mIo[ioPort / 32][ioPort % 32] ? 5 : 0;
    return 0;
  endfunction

  // one clock: predict, let the edge pass, compare away from the edge
  task automatic cycle(string tag);
    int r = 0, q = 0;
    if (guestMode) begin
      if (extIrq && mCtrl[7]) r = 1;
      else if (evValid && evIsExc && mExc[excVector]) begin r = 2; q = excVector; end
      else if (evValid && !evIsExc && instrReason(instrClass) != 0) begin
        r = instrReason(instrClass);
        if (r == 3) q = instrClass;
        else if (r == 4) q = gprIdx * 256 + crWrite * 16 + crNum;
        else q = ioPort;
      end
      else if (mCtrl[8] && !mWinDone && guestIf) r = 6;
    end
    expTrap = (r != 0);
    if (r != 0) begin expReason = r; expQual = q; end
    @(posedge clk);
    if (cfgWe) begin
      if (cfgAddr == 0) mCtrl = cfgData[11:0];
      else if (cfgAddr == 1) mExc = cfgData;
      else if (cfgAddr >= 2 && cfgAddr <= 9) mIo[cfgAddr-2] = cfgData;
    end
    if (cfgWe && cfgAddr == 0) mWinDone = 0;
    else if (r == 6) mWinDone = 1;
    @(negedge clk);
    check(tag, "trapPulse", trapPulse, expTrap);
    check(tag, "exitReason", exitReason, expReason);
    check(tag, "exitQual", exitQual, expQual);
    check(tag, "intMasked", intMasked, !mCtrl[7] && !guestIf);
  endtask

  task automatic clearEv();
    evValid = 0; evIsExc = 0; extIrq = 0; cfgWe = 0;
    instrClass = 4'd15; crWrite = 0; crNum = 0; gprIdx = 0;
  endtask

  task automatic cfg(int addr, int data, string tag);
    clearEv(); cfgWe = 1; cfgAddr = 4'(addr); cfgData = data;
    cycle(tag); cfgWe = 0;
  endtask

  task automatic ins(int cls, string tag);
    clearEv(); evValid = 1; instrClass = 4'(cls); cycle(tag); clearEv();
  endtask

  task automatic exc(int vec, string tag);
    clearEv(); evValid = 1; evIsExc = 1; excVector = 5'(vec); cycle(tag); clearEv();
  endtask

  task automatic io(int port, string tag);
    clearEv(); evValid = 1; instrClass = 4'd11; ioPort = 8'(port); cycle(tag); clearEv();
  endtask

  task automatic crm(int num, bit wr, int gpr, string tag);
    clearEv(); evValid = 1; instrClass = 4'd10; crNum = 4'(num); crWrite = wr;
    gprIdx = 4'(gpr); cycle(tag); clearEv();
  endtask

  task automatic idle(string tag);
    clearEv(); cycle(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (mIo[i]) mIo[i] = 0;
    clearEv();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    check("R1", "trapPulse", trapPulse, 0);
    check("R1", "exitReason", exitReason, 0);
    check("R1", "exitQual", exitQual, 0);
    check("R1", "intMasked", intMasked, 1);
    idle("R1");

    ins(0, "R10");                 // guest mode off
    guestMode = 1;
    ins(0, "R2"); idle("R11");
    ins(1, "R2"); ins(2, "R2");
    crm(3, 0, 5, "R2"); crm(0, 0, 5, "R8");
    ins(3, "R3"); ins(12, "R3");

    cfg(0, 32'h0000_0044, "R3");   // enable classes 5 and 9
    ins(5, "R3"); ins(6, "R3"); ins(9, "R3"); ins(15, "R3");

    exc(14, "R4");
    cfg(1, 32'h8000_4000, "R4");
    exc(14, "R4"); exc(31, "R4"); exc(13, "R4");

    io(8'h61, "R5");
    cfg(5, 32'h0000_0002, "R5");
    cfg(9, 32'h8000_0000, "R5");
    io(8'h61, "R5"); io(8'h60, "R5"); io(8'hFF, "R5");

    cfg(0, 32'h0000_0A00, "R8");   // CR0 and CR4 writes trap
    crm(0, 1, 2, "R8"); crm(3, 1, 2, "R8"); crm(4, 1, 7, "R8"); crm(5, 1, 1, "R8");
    cfg(0, 32'h0000_0400, "R8");
    crm(3, 1, 9, "R8");

    clearEv(); extIrq = 1; guestIf = 1; cycle("R6"); guestIf = 0; cycle("R6");
    cfg(0, 32'h0000_0080, "R6");
    clearEv(); extIrq = 1; cycle("R6"); guestIf = 1; cycle("R6"); guestIf = 0;
    guestMode = 0; cycle("R10"); guestMode = 1;

    cfg(0, 32'h0000_0180, "R7");   // both interrupt exits
    clearEv(); extIrq = 1; evValid = 1; evIsExc = 1; excVector = 14; cycle("R9");
    clearEv(); guestIf = 1;
    evValid = 1; evIsExc = 1; excVector = 31; cycle("R9");
    clearEv(); evValid = 1; instrClass = 0; cycle("R9");
    idle("R9"); idle("R7"); idle("R7");
    guestIf = 0;
    cfg(0, 32'h0000_0100, "R7");
    idle("R7"); guestIf = 1; idle("R7"); idle("R7"); guestIf = 0; idle("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule